// File: doc/BRIEF.md
# DMA Transfer Channel Controller

This block is one direct-memory-access channel. A peripheral raises a request line when it has a byte to move. The channel then asks the system bus for ownership with a hold request and waits for the hold acknowledge. Once it owns the bus, it runs byte transfer cycles without the processor. In each cycle it drives a memory address from its current-address register, strobes the acknowledge line back to the peripheral, and decrements its byte counter.

Software sets up the channel with one configuration strobe. The strobe loads the transfer mode, the address direction, the auto-reload option, a base address and a base count. It also returns the channel to idle and unmasks it. The mode decides when the bus is handed back:
- **Single:** after every byte.
- **Block:** only when the count is exhausted.
- **Demand:** as soon as the peripheral withdraws its request. A later request resumes from the saved address and count.
- **Cascade:** the channel generates no addresses. It only forwards a downstream controller's request to the bus and passes the grant back.

Top module: `dma_channel_ctrl`

## Requirements
- R1: After reset the channel is masked. `bus_hold_req`, `dev_ack`, `mem_addr_en` and `tc_pulse` are low, and `dev_req` is ignored until the first `cfg_load`.
- R2: When the channel is unmasked, `dev_req` is high and `bus_hold_ack` is low, `bus_hold_req` rises on the next clock. No transfer cycle (`dev_ack` or `mem_addr_en`) starts until `bus_hold_ack` has been seen high.
- R3: The mode field `cfg_mode` selects the mode: 0 single, 1 block, 2 demand, 3 cascade. In single mode (0) each byte gets its own bus tenure, and `bus_hold_req` drops in the cycle after every transfer cycle.
- R4: In block mode (1) all bytes are transferred in back-to-back cycles within one tenure, whatever `dev_req` does meanwhile.
- R5: In demand mode (2) transfers continue while `dev_req` is high. If `dev_req` is low during a transfer cycle, that byte completes and the bus is released. A later `dev_req` resumes at the next address and the remaining count.
- R6: In cascade mode (3) the channel raises `bus_hold_req` for `dev_req`. It holds `dev_ack` high while granted and `dev_req` stays high. `mem_addr_en` never goes high, and the bus is released one cycle after `dev_req` drops.
- R7: Each transfer cycle presents `mem_addr` with `mem_addr_en` high. The address then moves by one: it decrements when `cfg_down` is 1 and increments when it is 0, wrapping modulo 2^ADDR_W. A loaded count N moves N+1 bytes.
- R8: `tc_pulse` is high for exactly one cycle, in the cycle right after the final byte, and the bus is released at that point in every mode.
- R9: With `cfg_autoinit` set, the base address and base count are reloaded at terminal count and the channel stays unmasked. The next request starts again at the base address.
- R10: Without `cfg_autoinit`, terminal count masks the channel, and `dev_req` then raises no hold request until the next `cfg_load`.
- R11: `cfg_load` takes effect on the next clock edge in any state. It drops any bus tenure, loads all registers and unmasks the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration strobe: load all fields below |
| cfg_mode | input | 2 | Transfer mode: 0 single, 1 block, 2 demand, 3 cascade |
| cfg_down | input | 1 | 1: address decrements per byte; 0: increments |
| cfg_autoinit | input | 1 | Reload base address and count at terminal count |
| cfg_base_addr | input | ADDR_W | Start address |
| cfg_base_cnt | input | CNT_W | Byte count minus one |
| dev_req | input | 1 | Peripheral (or downstream controller) request |
| dev_ack | output | 1 | Acknowledge to the peripheral during transfer / grant |
| bus_hold_req | output | 1 | Request for system bus ownership |
| bus_hold_ack | input | 1 | Bus ownership granted |
| mem_addr | output | ADDR_W | Memory address of the current byte |
| mem_addr_en | output | 1 | A byte transfer cycle is in progress this cycle |
| tc_pulse | output | 1 | One-cycle terminal-count indication |

## Verification
The bench builds the block with its default 16-bit address and 16-bit count. Starting a decrementing single-mode run at address 0x0001 therefore carries the address through zero to 0xFFFF within three bytes. Small loaded counts keep every mode's full run to a handful of cycles, so the same test can check the terminal-count pulse, the mask and the auto-reload behaviour straight after. Bus grants are modelled as following the hold request by half a cycle. The grant can also be withheld, which shows that no transfer begins before ownership.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE  = 2'd0,
        XM_BLOCK   = 2'd1,
        XM_DEMAND  = 2'd2,
        XM_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_XFER = 2'd2,
        SQ_CASC = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_down,
    input  logic              cfg_autoinit,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    input  logic [CNT_W-1:0]  cfg_base_cnt,
    input  logic              step,
    output xfer_mode_e        mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_byte,
    output logic              chan_masked,
    output logic              tc_pulse
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [ADDR_W-1:0] cur_addr;
        logic [CNT_W-1:0]  cur_cnt;
        xfer_mode_e        mode;
        logic              down;
        logic              autoinit;
        logic              masked;
        logic              tc;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d    = regs_q;
        regs_d.tc = 1'b0;
        if (cfg_load) begin
            regs_d.base_addr = cfg_base_addr;
            regs_d.base_cnt  = cfg_base_cnt;
            regs_d.cur_addr  = cfg_base_addr;
            regs_d.cur_cnt   = cfg_base_cnt;
            regs_d.mode      = xfer_mode_e'(cfg_mode);
            regs_d.down      = cfg_down;
            regs_d.autoinit  = cfg_autoinit;
            regs_d.masked    = 1'b0;
        end else if (step) begin
            regs_d.cur_addr = regs_q.down ? regs_q.cur_addr - ADDR_ONE
                                          : regs_q.cur_addr + ADDR_ONE;
            regs_d.cur_cnt  = regs_q.cur_cnt - CNT_ONE;
            if (regs_q.cur_cnt == CNT_ZERO) begin
                regs_d.tc = 1'b1;
                if (regs_q.autoinit) begin
                    regs_d.cur_addr = regs_q.base_addr;
                    regs_d.cur_cnt  = regs_q.base_cnt;
                end else begin
                    regs_d.masked = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.mode     <= XM_SINGLE;
            regs_q.masked   <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode        = regs_q.mode;
    assign cur_addr    = regs_q.cur_addr;
    assign last_byte   = (regs_q.cur_cnt == CNT_ZERO);
    assign chan_masked = regs_q.masked;
    assign tc_pulse    = regs_q.tc;

    // R8: terminal count never lasts longer than one cycle
    a_r8_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    // R7: one step of the address per transferred byte, in the loaded direction
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_load && !last_byte) |=>
        (cur_addr == ($past(regs_q.down) ? $past(cur_addr) - ADDR_ONE
                                         : $past(cur_addr) + ADDR_ONE)));

    // R9: auto-reload restores the base address at terminal count
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_load && last_byte && regs_q.autoinit) |=>
        (cur_addr == $past(regs_q.base_addr) && !chan_masked));

    // R10: terminal count without auto-reload masks the channel
    a_r10_mask_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cfg_load && last_byte && !regs_q.autoinit) |=> chan_masked);

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_load,
    input  xfer_mode_e mode,
    input  logic       chan_masked,
    input  logic       last_byte,
    input  logic       dev_req,
    input  logic       bus_hold_ack,
    output logic       hold_req,
    output logic       dev_ack,
    output logic       addr_en,
    output logic       step
);

    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (!chan_masked && dev_req && !bus_hold_ack)
                    seq_d.st = SQ_REQ;
            end
            SQ_REQ: begin
                if (bus_hold_ack)
                    seq_d.st = (mode == XM_CASCADE) ? SQ_CASC : SQ_XFER;
            end
            SQ_XFER: begin
                if (last_byte) begin
                    seq_d.st = SQ_IDLE;
                end else begin
                    unique case (mode)
                        XM_BLOCK:  seq_d.st = SQ_XFER;
                        XM_DEMAND: seq_d.st = dev_req ? SQ_XFER : SQ_IDLE;
                        default:   seq_d.st = SQ_IDLE;
                    endcase
                end
            end
            SQ_CASC: begin
                if (!dev_req)
                    seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
        if (cfg_load)
            seq_d.st = SQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q.st <= SQ_IDLE;
        else        seq_q    <= seq_d;
    end

    assign hold_req = (seq_q.st != SQ_IDLE);
    assign dev_ack  = (seq_q.st == SQ_XFER) || (seq_q.st == SQ_CASC);
    assign addr_en  = (seq_q.st == SQ_XFER);
    assign step     = (seq_q.st == SQ_XFER) && !cfg_load;

    // R2: an acknowledge to the device only starts after the bus was granted
    a_r2_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> $past(bus_hold_ack));

    // R3: single mode hands the bus back after every byte
    a_r3_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && mode == XM_SINGLE && !cfg_load) |=> !hold_req);

    // R6: cascade never drives addresses
    a_r6_casc_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_CASCADE) |-> !addr_en);

    // R11: a configuration strobe ends any tenure
    a_r11_load_idles: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !hold_req);

endmodule

// File: rtl/dma_channel_ctrl.sv
module dma_channel_ctrl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_down,
    input  logic              cfg_autoinit,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    input  logic [CNT_W-1:0]  cfg_base_cnt,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              bus_hold_req,
    input  logic              bus_hold_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_addr_en,
    output logic              tc_pulse
);

    xfer_mode_e mode;
    logic       last_byte;
    logic       chan_masked;
    logic       step;

    dma_xfer_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_mode     (cfg_mode),
        .cfg_down     (cfg_down),
        .cfg_autoinit (cfg_autoinit),
        .cfg_base_addr(cfg_base_addr),
        .cfg_base_cnt (cfg_base_cnt),
        .step         (step),
        .mode         (mode),
        .cur_addr     (mem_addr),
        .last_byte    (last_byte),
        .chan_masked  (chan_masked),
        .tc_pulse     (tc_pulse)
    );

    dma_bus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .mode        (mode),
        .chan_masked (chan_masked),
        .last_byte   (last_byte),
        .dev_req     (dev_req),
        .bus_hold_ack(bus_hold_ack),
        .hold_req    (bus_hold_req),
        .dev_ack     (dev_ack),
        .addr_en     (mem_addr_en),
        .step        (step)
    );

    // R8: terminal count is reported with the bus already released
    a_r8_tc_released: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> !mem_addr_en);

endmodule

// File: tb/dma_channel_ctrl_tb.sv
module dma_channel_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic        down;
        logic        autoi;
        logic [15:0] base;
        logic [15:0] cnt;
        logic [7:0]  bytes;
        logic [7:0]  holds;
        logic [15:0] last;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 1'b0, 1'b0, 16'h1000, 16'd3, 8'd4, 8'd4, 16'h1003},
        '{2'd1, 1'b0, 1'b0, 16'h2000, 16'd4, 8'd5, 8'd1, 16'h2004},
        '{2'd1, 1'b1, 1'b0, 16'h3000, 16'd2, 8'd3, 8'd1, 16'h2FFE},
        '{2'd2, 1'b0, 1'b0, 16'h4000, 16'd5, 8'd6, 8'd1, 16'h4005},
        '{2'd1, 1'b0, 1'b1, 16'h5000, 16'd1, 8'd2, 8'd1, 16'h5001},
        '{2'd0, 1'b1, 1'b0, 16'h0001, 16'd2, 8'd3, 8'd3, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_down = 1'b0;
    logic        cfg_autoinit = 1'b0;
    logic [15:0] cfg_base_addr = '0;
    logic [15:0] cfg_base_cnt = '0;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic        bus_hold_req;
    logic        bus_hold_ack = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_addr_en;
    logic        tc_pulse;

    int          n_tests = 0;
    int          n_fail = 0;
    int          n_bytes, n_holds, n_tc, n_seqerr;
    logic [15:0] last_addr, mon_base;
    logic        mon_down;
    logic        prev_hold = 1'b0;
    logic        ack_block = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_channel_ctrl #(.ADDR_W(16), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_down(cfg_down), .cfg_autoinit(cfg_autoinit),
        .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt),
        .dev_req(dev_req), .dev_ack(dev_ack), .bus_hold_req(bus_hold_req),
        .bus_hold_ack(bus_hold_ack), .mem_addr(mem_addr),
        .mem_addr_en(mem_addr_en), .tc_pulse(tc_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: bus model and monitor, all at the falling edge
    task automatic tick();
        logic [15:0] exp_a;
        @(negedge clk);
        bus_hold_ack = ack_block ? 1'b0 : bus_hold_req;
        if (mem_addr_en) begin
            exp_a = mon_down ? mon_base - 16'(n_bytes) : mon_base + 16'(n_bytes);
            if (mem_addr !== exp_a) n_seqerr++;
            last_addr = mem_addr;
            n_bytes++;
        end
        if (bus_hold_req && !prev_hold) n_holds++;
        prev_hold = bus_hold_req;
        if (tc_pulse) n_tc++;
    endtask

    task automatic mon_reset(input logic [15:0] base, input logic down);
        n_bytes = 0; n_holds = 0; n_tc = 0; n_seqerr = 0;
        mon_base = base; mon_down = down; last_addr = '0;
    endtask

    task automatic load_cfg(input logic [1:0] m, input logic dn, input logic ai,
                            input logic [15:0] base, input logic [15:0] cnt);
        cfg_mode = m; cfg_down = dn; cfg_autoinit = ai;
        cfg_base_addr = base; cfg_base_cnt = cnt;
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic run_until_tc(input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            tick();
            if (tc_pulse) begin
                dev_req = 1'b0;
                break;
            end
        end
        dev_req = 1'b0;
        tick(); tick();
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R3 single";
            2'd1:    return "R4 block";
            2'd2:    return "R5 demand";
            default: return "R6 cascade";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        mon_reset(16'h0, 1'b0);
        dev_req = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        // R1: reset state, request ignored while masked
        chk(!bus_hold_req && !dev_ack && !mem_addr_en && !tc_pulse && n_holds == 0,
            "R1 reset idle and masked", n_holds, 0);
        dev_req = 1'b0;
        tick();

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            load_cfg(TBL[v].mode, TBL[v].down, TBL[v].autoi, TBL[v].base, TBL[v].cnt);
            mon_reset(TBL[v].base, TBL[v].down);
            dev_req = 1'b1;
            run_until_tc(80);
            chk(n_bytes == int'(TBL[v].bytes), {mode_tag(TBL[v].mode), " R7 byte count"},
                n_bytes, TBL[v].bytes);
            chk(n_holds == int'(TBL[v].holds), {mode_tag(TBL[v].mode), " tenures"},
                n_holds, TBL[v].holds);
            chk(last_addr == TBL[v].last, "R7 final address", last_addr, TBL[v].last);
            chk(n_seqerr == 0, "R7 address sequence", n_seqerr, 0);
            chk(n_tc == 1, "R8 terminal count pulse width", n_tc, 1);
            mon_reset(TBL[v].base, TBL[v].down);
            dev_req = 1'b1;
            if (TBL[v].autoi) begin
                run_until_tc(80);
                chk(n_bytes == int'(TBL[v].bytes) && n_seqerr == 0,
                    "R9 auto-reload restart", n_bytes, TBL[v].bytes);
            end else begin
                for (int i = 0; i < 10; i++) tick();
                dev_req = 1'b0;
                tick();
                chk(n_holds == 0, "R10 masked after terminal count", n_holds, 0);
            end
        end

        // R2: no transfer without grant
        load_cfg(2'd0, 1'b0, 1'b0, 16'h8000, 16'd0);
        mon_reset(16'h8000, 1'b0);
        ack_block = 1'b1;
        dev_req = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        chk(bus_hold_req && !dev_ack && n_bytes == 0, "R2 waits for grant", n_bytes, 0);
        ack_block = 1'b0;
        run_until_tc(20);
        chk(n_bytes == 1 && last_addr == 16'h8000, "R2 transfer after grant",
            last_addr, 16'h8000);

        // R5: demand pause and resume
        load_cfg(2'd2, 1'b0, 1'b0, 16'h6000, 16'd5);
        mon_reset(16'h6000, 1'b0);
        dev_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (n_bytes == 2) break;
        end
        dev_req = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk(n_bytes == 2 && !bus_hold_req, "R5 demand pause releases bus", n_bytes, 2);
        dev_req = 1'b1;
        run_until_tc(40);
        chk(n_bytes == 6 && n_seqerr == 0, "R5 demand resume continues", n_bytes, 6);
        chk(n_holds == 2, "R5 demand two tenures", n_holds, 2);

        // R6: cascade pass-through
        load_cfg(2'd3, 1'b0, 1'b0, 16'h9000, 16'd0);
        mon_reset(16'h9000, 1'b0);
        dev_req = 1'b1;
        tick(); tick(); tick();
        begin
            int good = 0;
            for (int i = 0; i < 4; i++) begin
                if (dev_ack && bus_hold_req && !mem_addr_en) good++;
                tick();
            end
            chk(good == 4, "R6 cascade grant passed through", good, 4);
        end
        dev_req = 1'b0;
        tick();
        chk(!bus_hold_req && !dev_ack && n_bytes == 0, "R6 cascade release, no addresses",
            n_bytes, 0);

        // R11: load mid-transfer aborts and reloads
        load_cfg(2'd1, 1'b0, 1'b0, 16'h7000, 16'd20);
        mon_reset(16'h7000, 1'b0);
        dev_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (n_bytes == 3) break;
        end
        dev_req = 1'b0;
        load_cfg(2'd1, 1'b0, 1'b0, 16'h7100, 16'd1);
        chk(!bus_hold_req && !dev_ack, "R11 load ends tenure", bus_hold_req, 0);
        tick();
        mon_reset(16'h7100, 1'b0);
        dev_req = 1'b1;
        run_until_tc(40);
        chk(n_bytes == 2 && n_seqerr == 0 && last_addr == 16'h7101,
            "R11 new registers in use", last_addr, 16'h7101);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule